// File: doc/BRIEF.md
# Two-Lane Transmit Three-Tap FIR Level Generator

This block is the digital front end of a serial transmit equalizer. Each lane accepts one NRZ bit per symbol. It keeps a three-bit history of that lane's bits and forms a signed level code for a downstream DAC. The code has three parts: the main cursor, a pre-cursor term taken from the bit that follows the main bit, and a post-cursor term taken from the bit that precedes it. Each bit counts as +1 or -1 before weighting. The sum is scaled by a 16-step swing setting. The two cursor weights are negative fractions of the main tap, set in steps of 1/128.

Each lane has its own swing code, its own two cursor weights and its own polarity-invert flag. They are written through a shared byte-wide write port that carries a lane select and a two-bit field address. A write first lands in a staging copy. It reaches the live coefficient set only on a symbol strobe, so a symbol is never built from a half-updated coefficient set. The strobe `sym_en` marks each symbol. Between strobes, the history, the live settings and the output all hold. The level is registered and appears one clock after the strobe that shifts the symbol in.

Top module: `tx_ffe_pair`

## Requirements
- R1: After the strobe that takes bit x[k+1], the main bit is x[k], the pre-cursor bit is x[k+1] and the post-cursor bit is x[k-1]. Bit value 1 counts as +1 and 0 counts as -1. One clock after that strobe the lane level is A*(128*m - wpre*p - wpost*q), where m, p and q are the signed main, pre and post bits.
- R2: The history shifts only on a clock edge where `sym_en` is 1. With `sym_en` at 0 the history and the level hold.
- R3: Swing code c (0..15) gives the multiplier A = AMP_MIN + c*AMP_STEP. The default is 4 + c, which is 200..950 mV in 50 mV units.
- R4: A weight field value w means a cursor gain of -w/128. A written value above 128 is stored as 128.
- R5: A write with `cfg_wr` = 1 targets the lane `cfg_lane`. The field is chosen by `cfg_addr`: 0 is swing (low 4 bits of `cfg_data`), 1 is the pre-cursor weight, 2 is the post-cursor weight, and 3 is polarity invert (bit 0).
- R6: The level is saturated to [-2^(OUT_W-1), 2^(OUT_W-1)-1] and never wraps. The default OUT_W = 14 holds the worst case of ±7296 exactly.
- R7: A written value is used starting at the first strobe edge strictly after the write edge. A write made on the same edge as a strobe waits for the next strobe.
- R8: With polarity invert set, all three history bits are complemented before weighting, so the lane level is negated.
- R9: Each lane's settings and history affect only that lane's level.
- R10: In reset the level is 0. After reset the weights are 0, the swing code is 0, polarity is normal and the history is all zeros, so each lane settles at -512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_en | input | 1 | Symbol strobe: shift bits in and commit staged settings |
| tx_bit | input | NUM_LANES | One NRZ data bit per lane |
| cfg_wr | input | 1 | Setting write enable |
| cfg_lane | input | LANE_W | Lane select for the write |
| cfg_addr | input | 2 | Field select: 0 swing, 1 pre, 2 post, 3 invert |
| cfg_data | input | CFG_W | Write data |
| tx_level | output | NUM_LANES*OUT_W | Signed level per lane, lane 0 in the low bits |

## Verification
The bench builds two copies of the block that share all inputs. The first copy uses the default OUT_W of 14, which is wide enough that every level, including the ±7296 extremes, must come out exact. The second copy uses OUT_W = 10. There, the largest swing setting already exceeds the range with the main tap alone, and the extreme cursor patterns drive the level hard into both rails. This puts the clamping at both ends within reach without changing the stimulus. All other settings stay at their defaults, so the swing mapping covers the stated 4..19 range.

// File: rtl/tx_ffe_pkg.sv
// Shared definitions for the transmit FIR level generator.
// Assumes a two-bit field address on the setting write port.
package tx_ffe_pkg;

    typedef enum logic [1:0] {
        FLD_SWING  = 2'd0,
        FLD_PRE    = 2'd1,
        FLD_POST   = 2'd2,
        FLD_INVERT = 2'd3
    } ffe_field_e;

endpackage

// File: rtl/tx_ffe_regs.sv
// Per-lane setting store with a staging copy and a live copy.
// Writes land in staging; the live set takes the staging values on a
// symbol strobe so a symbol never sees a partly updated set.
// Assumes CFG_W >= WT_W and CFG_W >= AMP_W.
module tx_ffe_regs
    import tx_ffe_pkg::*;
#(
    parameter int AMP_W   = 4,
    parameter int WT_FRAC = 7,
    parameter int CFG_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sym_en,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [CFG_W-1:0]    wr_data,
    output logic [AMP_W-1:0]    act_amp,
    output logic [WT_FRAC:0]    act_pre,
    output logic [WT_FRAC:0]    act_post,
    output logic                act_inv
);

    localparam int WT_W   = WT_FRAC + 1;
    localparam int WT_MAX = 1 << WT_FRAC;

    logic [AMP_W-1:0] stg_amp;
    logic [WT_W-1:0]  stg_pre;
    logic [WT_W-1:0]  stg_post;
    logic             stg_inv;
    logic [WT_W-1:0]  wt_clamped;

    // Limit a written weight to a gain of at most -1.
    always_comb begin
        if (wr_data > CFG_W'(WT_MAX)) begin
            wt_clamped = WT_W'(WT_MAX);
        end else begin
            wt_clamped = WT_W'(wr_data);
        end
    end

    // Capture writes into the staging copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_amp  <= '0;
            stg_pre  <= '0;
            stg_post <= '0;
            stg_inv  <= 1'b0;
        end else if (wr_en) begin
            case (ffe_field_e'(wr_addr))
                FLD_SWING:  stg_amp  <= wr_data[AMP_W-1:0];
                FLD_PRE:    stg_pre  <= wt_clamped;
                FLD_POST:   stg_post <= wt_clamped;
                FLD_INVERT: stg_inv  <= wr_data[0];
                default:    stg_inv  <= stg_inv;
            endcase
        end
    end

    // Move staging into the live set on a symbol boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_amp  <= '0;
            act_pre  <= '0;
            act_post <= '0;
            act_inv  <= 1'b0;
        end else if (sym_en) begin
            act_amp  <= stg_amp;
            act_pre  <= stg_pre;
            act_post <= stg_post;
            act_inv  <= stg_inv;
        end
    end

    p_wt_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_pre <= WT_W'(WT_MAX)) && (act_post <= WT_W'(WT_MAX)));

    p_live_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_en |=> ($stable(act_amp) && $stable(act_pre) &&
                     $stable(act_post) && $stable(act_inv)));

    p_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sym_en |=> (act_amp == $past(stg_amp) && act_pre == $past(stg_pre) &&
                    act_post == $past(stg_post) && act_inv == $past(stg_inv)));

endmodule

// File: rtl/tx_ffe_tap.sv
// Three-bit symbol history for one lane.
// hist[0] is the newest bit (pre-cursor), hist[1] the main bit,
// hist[2] the oldest bit (post-cursor). Shifts only on sym_en.
module tx_ffe_tap (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_en,
    input  logic       bit_in,
    output logic [2:0] hist
);

    // Shift one symbol into the history window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= 3'b000;
        end else if (sym_en) begin
            hist <= {hist[1:0], bit_in};
        end
    end

    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sym_en |=> (hist == {$past(hist[1:0]), $past(bit_in)}));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_en |=> $stable(hist));

endmodule

// File: rtl/tx_ffe_sum.sv
// Weighted sum, saturation and output register for one lane.
// Level = A*(128*m - wpre*p - wpost*q) with bits mapped to +1/-1 and
// optionally complemented. Assumes AMP_MIN > 0 and that the products
// fit in 32 signed bits for the chosen parameters.
module tx_ffe_sum #(
    parameter int AMP_W    = 4,
    parameter int AMP_MIN  = 4,
    parameter int AMP_STEP = 1,
    parameter int WT_FRAC  = 7,
    parameter int OUT_W    = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              hist,
    input  logic [AMP_W-1:0]        amp,
    input  logic [WT_FRAC:0]        pre_wt,
    input  logic [WT_FRAC:0]        post_wt,
    input  logic                    inv,
    output logic signed [OUT_W-1:0] level
);

    localparam int MAIN_WT = 1 << WT_FRAC;
    localparam int SAT_HI  = (1 << (OUT_W - 1)) - 1;
    localparam int SAT_LO  = -(1 << (OUT_W - 1));

    logic [2:0] sbit;
    int         amp_lin;
    int         t_main;
    int         t_pre;
    int         t_post;
    int         acc_v;
    int         sat_v;

    // Apply polarity to the history bits.
    always_comb sbit = hist ^ {3{inv}};

    // Form the tap terms and the scaled sum.
    always_comb begin
        amp_lin = AMP_MIN + int'(amp) * AMP_STEP;
        t_main  = sbit[1] ? MAIN_WT : -MAIN_WT;
        t_pre   = sbit[0] ? -int'(pre_wt)  : int'(pre_wt);
        t_post  = sbit[2] ? -int'(post_wt) : int'(post_wt);
        acc_v   = amp_lin * (t_main + t_pre + t_post);
    end

    // Clamp to the output range.
    always_comb begin
        if (acc_v > SAT_HI) begin
            sat_v = SAT_HI;
        end else if (acc_v < SAT_LO) begin
            sat_v = SAT_LO;
        end else begin
            sat_v = acc_v;
        end
    end

    // Register the level toward the DAC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            level <= OUT_W'(sat_v);
        end
    end

    p_main_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pre_wt) == '0 && $past(post_wt) == '0) |->
        (level[OUT_W-1] == ~($past(hist[1]) ^ $past(inv))));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(acc_v > SAT_HI)) |-> (level == OUT_W'(SAT_HI)));

    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(acc_v < SAT_LO)) |-> (level == OUT_W'(SAT_LO)));

endmodule

// File: rtl/tx_ffe_pair.sv
// Multi-lane transmit three-tap FIR level generator.
// One history, setting store and weighted-sum stage per lane; a shared
// write port addresses one lane at a time. Assumes sym_en is common to
// all lanes.
module tx_ffe_pair #(
    parameter int NUM_LANES = 2,
    parameter int AMP_W     = 4,
    parameter int AMP_MIN   = 4,
    parameter int AMP_STEP  = 1,
    parameter int WT_FRAC   = 7,
    parameter int CFG_W     = 8,
    parameter int OUT_W     = 14,
    localparam int LANE_W   = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sym_en,
    input  logic [NUM_LANES-1:0]       tx_bit,
    input  logic                       cfg_wr,
    input  logic [LANE_W-1:0]          cfg_lane,
    input  logic [1:0]                 cfg_addr,
    input  logic [CFG_W-1:0]           cfg_data,
    output logic [NUM_LANES*OUT_W-1:0] tx_level
);

    for (genvar li = 0; li < NUM_LANES; li++) begin : g_lane
        logic                    lane_wr;
        logic [2:0]              hist;
        logic [AMP_W-1:0]        amp;
        logic [WT_FRAC:0]        pre_wt;
        logic [WT_FRAC:0]        post_wt;
        logic                    inv;
        logic signed [OUT_W-1:0] lvl;

        // Route a write to this lane only.
        always_comb lane_wr = cfg_wr && (cfg_lane == LANE_W'(li));

        tx_ffe_regs #(
            .AMP_W   (AMP_W),
            .WT_FRAC (WT_FRAC),
            .CFG_W   (CFG_W)
        ) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .sym_en   (sym_en),
            .wr_en    (lane_wr),
            .wr_addr  (cfg_addr),
            .wr_data  (cfg_data),
            .act_amp  (amp),
            .act_pre  (pre_wt),
            .act_post (post_wt),
            .act_inv  (inv)
        );

        tx_ffe_tap u_tap (
            .clk    (clk),
            .rst_n  (rst_n),
            .sym_en (sym_en),
            .bit_in (tx_bit[li]),
            .hist   (hist)
        );

        tx_ffe_sum #(
            .AMP_W    (AMP_W),
            .AMP_MIN  (AMP_MIN),
            .AMP_STEP (AMP_STEP),
            .WT_FRAC  (WT_FRAC),
            .OUT_W    (OUT_W)
        ) u_sum (
            .clk     (clk),
            .rst_n   (rst_n),
            .hist    (hist),
            .amp     (amp),
            .pre_wt  (pre_wt),
            .post_wt (post_wt),
            .inv     (inv),
            .level   (lvl)
        );

        assign tx_level[li*OUT_W +: OUT_W] = lvl;
    end

endmodule

// File: tb/tx_ffe_pair_test.sv
// Bench for tx_ffe_pair: a wide copy (uut) and a narrow copy (uut_sat)
// share all inputs; a bench-side model built from the requirements
// gives the expected levels.
module tx_ffe_pair_test;

    localparam int OW_D = 14;
    localparam int OW_S = 10;
    localparam int NPAT = 16;
    // Per entry: {lane1 bit, lane0 bit}
    localparam logic [1:0] PAT [NPAT] = '{
        2'b00, 2'b11, 2'b01, 2'b10, 2'b11, 2'b00, 2'b10, 2'b01,
        2'b11, 2'b11, 2'b00, 2'b01, 2'b01, 2'b10, 2'b00, 2'b11
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sym_en = 1'b0;
    logic [1:0]       tx_bit = '0;
    logic             cfg_wr = 1'b0;
    logic [0:0]       cfg_lane = '0;
    logic [1:0]       cfg_addr = '0;
    logic [7:0]       cfg_data = '0;
    logic [2*OW_D-1:0] lvl_d;
    logic [2*OW_S-1:0] lvl_s;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_stg_amp [2], m_stg_pre [2], m_stg_post [2], m_stg_inv [2];
    int m_amp [2], m_pre [2], m_post [2], m_inv [2];
    int m_h0 [2], m_h1 [2], m_h2 [2];

    always #4 clk = ~clk;

    tx_ffe_pair uut (
        .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .tx_bit(tx_bit),
        .cfg_wr(cfg_wr), .cfg_lane(cfg_lane), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .tx_level(lvl_d)
    );

    tx_ffe_pair #(.OUT_W(OW_S)) uut_sat (
        .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .tx_bit(tx_bit),
        .cfg_wr(cfg_wr), .cfg_lane(cfg_lane), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .tx_level(lvl_s)
    );

    function automatic int sgn(int b, int inv);
        return ((b ^ inv) != 0) ? 1 : -1;
    endfunction

    function automatic int model(int ln, int ow);
        int a, v, hi, lo;
        a  = 4 + m_amp[ln];
        v  = a * (128 * sgn(m_h1[ln], m_inv[ln])
                  - m_pre[ln] * sgn(m_h0[ln], m_inv[ln])
                  - m_post[ln] * sgn(m_h2[ln], m_inv[ln]));
        hi = (1 << (ow - 1)) - 1;
        lo = -(1 << (ow - 1));
        if (v > hi) v = hi;
        if (v < lo) v = lo;
        return v;
    endfunction

    function automatic void m_write(int ln, int addr, int data);
        case (addr)
            0: m_stg_amp[ln]  = data & 15;
            1: m_stg_pre[ln]  = (data > 128) ? 128 : data;
            2: m_stg_post[ln] = (data > 128) ? 128 : data;
            default: m_stg_inv[ln] = data & 1;
        endcase
    endfunction

    function automatic void m_strobe(logic [1:0] bits);
        for (int ln = 0; ln < 2; ln++) begin
            m_amp[ln]  = m_stg_amp[ln];
            m_pre[ln]  = m_stg_pre[ln];
            m_post[ln] = m_stg_post[ln];
            m_inv[ln]  = m_stg_inv[ln];
            m_h2[ln]   = m_h1[ln];
            m_h1[ln]   = m_h0[ln];
            m_h0[ln]   = int'(bits[ln]);
        end
    endfunction

    task automatic cmp(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Compare both lanes of both copies against the model.
    task automatic chk_all(string tag);
        for (int ln = 0; ln < 2; ln++) begin
            cmp(tag, int'($signed(lvl_d[ln*OW_D +: OW_D])), model(ln, OW_D));
            cmp(tag, int'($signed(lvl_s[ln*OW_S +: OW_S])), model(ln, OW_S));
        end
    endtask

    // One-cycle write; starts and ends just after a falling edge.
    task automatic wr(int ln, int addr, int data);
        cfg_wr = 1'b1; cfg_lane = 1'(ln); cfg_addr = 2'(addr); cfg_data = 8'(data);
        @(posedge clk);
        m_write(ln, addr, data);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // One symbol, optionally with a write on the same edge; waits for the level.
    task automatic sym(logic [1:0] bits, bit with_wr, int ln, int addr, int data);
        sym_en = 1'b1; tx_bit = bits;
        if (with_wr) begin
            cfg_wr = 1'b1; cfg_lane = 1'(ln); cfg_addr = 2'(addr); cfg_data = 8'(data);
        end
        @(posedge clk);
        m_strobe(bits);
        if (with_wr) m_write(ln, addr, data);
        @(negedge clk);
        sym_en = 1'b0; cfg_wr = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int ln = 0; ln < 2; ln++) begin
            m_stg_amp[ln] = 0; m_stg_pre[ln] = 0; m_stg_post[ln] = 0; m_stg_inv[ln] = 0;
            m_amp[ln] = 0; m_pre[ln] = 0; m_post[ln] = 0; m_inv[ln] = 0;
            m_h0[ln] = 0; m_h1[ln] = 0; m_h2[ln] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: level is 0 while in reset
        for (int ln = 0; ln < 2; ln++) begin
            cmp("R10 in reset", int'($signed(lvl_d[ln*OW_D +: OW_D])), 0);
            cmp("R10 in reset", int'($signed(lvl_s[ln*OW_S +: OW_S])), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R10: default settings give -512
        for (int ln = 0; ln < 2; ln++) begin
            cmp("R10 after reset", int'($signed(lvl_d[ln*OW_D +: OW_D])), -512);
            cmp("R10 after reset", int'($signed(lvl_s[ln*OW_S +: OW_S])), -512);
        end

        // R5: program both lanes through the write port
        wr(0, 0, 6);  wr(0, 1, 32); wr(0, 2, 16);
        wr(1, 0, 15); wr(1, 2, 64); wr(1, 3, 1);
        repeat (3) @(negedge clk);
        // R7: staged values not yet in use without a strobe
        for (int ln = 0; ln < 2; ln++)
            cmp("R7 staged only", int'($signed(lvl_d[ln*OW_D +: OW_D])), -512);

        // R1 R3 R8 R9: table walk
        for (int i = 0; i < NPAT; i++) begin
            sym(PAT[i], 1'b0, 0, 0, 0);
            chk_all("R1 R3 R8 R9 table");
        end

        // R2: no strobe, level holds
        repeat (5) @(negedge clk);
        chk_all("R2 hold");

        // R4: weight above 128 behaves as 128
        wr(0, 1, 200);
        sym(2'b01, 1'b0, 0, 0, 0);
        sym(2'b10, 1'b0, 0, 0, 0);
        chk_all("R4 clamp");

        // R7: write on the strobe edge waits for the next strobe
        sym(2'b11, 1'b1, 0, 0, 0);
        chk_all("R7 same edge old swing");
        sym(2'b00, 1'b0, 0, 0, 0);
        chk_all("R7 next strobe new swing");

        // R8: toggle lane 0 polarity
        wr(0, 3, 1);
        sym(2'b01, 1'b0, 0, 0, 0);
        chk_all("R8 invert");

        // R6: lane 1 at full swing and full weights, normal polarity
        wr(1, 1, 128); wr(1, 2, 128); wr(1, 3, 0);
        sym(2'b00, 1'b0, 0, 0, 0);
        sym(2'b10, 1'b0, 0, 0, 0);
        sym(2'b00, 1'b0, 0, 0, 0);
        chk_all("R6 positive extreme");
        cmp("R6 exact max", int'($signed(lvl_d[OW_D +: OW_D])), 7296);
        cmp("R6 rail high", int'($signed(lvl_s[OW_S +: OW_S])), 511);
        sym(2'b10, 1'b0, 0, 0, 0);
        sym(2'b00, 1'b0, 0, 0, 0);
        sym(2'b10, 1'b0, 0, 0, 0);
        chk_all("R6 negative extreme");
        cmp("R6 exact min", int'($signed(lvl_d[OW_D +: OW_D])), -7296);
        cmp("R6 rail low", int'($signed(lvl_s[OW_S +: OW_S])), -512);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule